// File: doc/BRIEF.md
# Capability Tag Cache Controller

This block tracks a one-bit validity tag for every 16-byte memory line. The tags are not stored next to the data. They live in a reserved table in ordinary memory. Each 128-bit word of that table holds the tags of 128 consecutive lines. A small direct-mapped cache of table words sits in front of the table and sends its misses and write-backs over a simple request/response memory port.

A client sends a line address and an operation: read a tag, set it, clear it, or clear a whole page. A page is the group of 128 lines that share one table word. A summary bit per page records whether the page may hold any set tag. While that bit is zero, reads and clears answer zero without touching memory. A set in such a page starts from an all-zero word instead of fetching one. Pages that hold no capabilities therefore never cause a table fetch.

The tag table costs 1/128 of the memory it covers. For example, 256 MB of memory needs about 2 MB of tags. The table base is a parameter, so each memory module can carry its own table, sized for that module.

Top module: `ctc_tag_cache`

## Requirements
- R1: The tag of line L sits in table word L>>7 at bit position L[6:0] (bit 0 = least significant bit of the word).
- R2: The memory port addresses table word W at byte address TBL_BASE + 16*W, for both fetches and write-backs.
- R3: req_op encodes 0 = read, 1 = set, 2 = clear, 3 = page clear. A read returns the stored tag. A set returns 1 and a clear returns 0, and a later read of the same line sees the new value.
- R4: While a page's summary bit is 0, reads and clears in that page answer 0 and issue no memory request. A set in that page installs an all-zero word and issues no fetch.
- R5: A set marks its page's summary bit. A page clear answers 0, and afterwards every tag of that page reads 0, including tags set before it.
- R6: On a cache hit, or on any request answered without memory, rsp_valid rises in the cycle after acceptance. req_ready stays low while a miss is outstanding. A memory request is held with a stable address until it is accepted.
- R7: A dirty victim word is written back before the new word is fetched or installed. A clean victim is never written back.
- R8: The cache has ENTRIES direct-mapped entries indexed by word[2:0] (for 8 entries). Words with different indices stay resident together.
- R9: Reset invalidates every cache entry and clears every page summary bit, so after reset all tags read 0 with no memory traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | Operation code (see R3) |
| req_line | input | LINE_AW | 16-byte line number |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_tag | output | 1 | Tag value after the operation |
| mem_req_valid | output | 1 | Table memory request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write-back, 0 = fetch |
| mem_req_addr | output | MEM_AW | Byte address of the table word |
| mem_req_wdata | output | 128 | Word written back |
| mem_rsp_valid | input | 1 | Memory completion strobe (reads and writes) |
| mem_rsp_rdata | input | 128 | Fetched table word |

## Verification
A hit, a summary-zero read or clear, and a page clear each answer exactly one cycle after acceptance. A set into an empty page takes two cycles. The bench counts falling edges from the accepting edge and checks these exact latencies. Misses that go to memory have a variable latency, because the bench memory toggles its ready and answers three cycles after acceptance. For those requests the bench waits for rsp_valid and then checks the value. It also checks the memory traffic: how many fetches and write-backs occurred, the last addresses used, and the written word. A clean victim must add no write. An empty page must add no fetch.

// File: rtl/ctc_pkg.sv
package ctc_pkg;

  localparam int TWORD_BITS = 128;
  localparam int TBIT_W     = 7;

  typedef enum logic [1:0] {
    OP_READ     = 2'd0,
    OP_SET      = 2'd1,
    OP_CLEAR    = 2'd2,
    OP_PAGE_CLR = 2'd3
  } ctc_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WB_REQ,
    ST_WB_WAIT,
    ST_DECIDE,
    ST_RD_REQ,
    ST_RD_WAIT
  } ctc_state_e;

  // Apply an operation to one tag word.
  function automatic logic [TWORD_BITS-1:0] ctc_apply(
    input logic [TWORD_BITS-1:0] w,
    input ctc_op_e               op,
    input logic [TBIT_W-1:0]     b
  );
    logic [TWORD_BITS-1:0] r;
    r = w;
    case (op)
      OP_SET:   r[b] = 1'b1;
      OP_CLEAR: r[b] = 1'b0;
      default:  r = w;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ctc_addr_map.sv
module ctc_addr_map #(
  parameter int LINE_AW = 16,
  parameter int ENTRIES = 8,
  localparam int WORD_AW = LINE_AW - ctc_pkg::TBIT_W,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int CTAG_W  = WORD_AW - IDX_W
) (
  input  logic [LINE_AW-1:0]        line,
  output logic [WORD_AW-1:0]        word,
  output logic [IDX_W-1:0]          idx,
  output logic [CTAG_W-1:0]         ctag,
  output logic [ctc_pkg::TBIT_W-1:0] bit_idx
);
  // R1: 128 lines per table word, low line bits select the bit.
  assign word    = line[LINE_AW-1:ctc_pkg::TBIT_W];
  assign bit_idx = line[ctc_pkg::TBIT_W-1:0];
  // R8: direct-mapped index from the low word bits.
  assign idx     = word[IDX_W-1:0];
  assign ctag    = word[WORD_AW-1:IDX_W];
endmodule

// File: rtl/ctc_page_summary.sv
module ctc_page_summary #(
  parameter int PAGE_W = 9,
  localparam int PAGES = 2 ** PAGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PAGE_W-1:0] rd_page,
  output logic              rd_bit,
  input  logic              set_en,
  input  logic [PAGE_W-1:0] set_page,
  input  logic              clr_en,
  input  logic [PAGE_W-1:0] clr_page
);
  logic [PAGES-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q <= '0;
    end else if (set_en) begin
      bits_q[set_page] <= 1'b1;
    end else if (clr_en) begin
      bits_q[clr_page] <= 1'b0;
    end
  end

  assign rd_bit = bits_q[rd_page];

  a_r5_set_marks_page: assert property (@(posedge clk) disable iff (rst)
    set_en |=> bits_q[$past(set_page)]);

  a_r5_clear_drops_page: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !set_en) |=> !bits_q[$past(clr_page)]);

  a_r9_summary_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (bits_q == '0));
endmodule

// File: rtl/ctc_tag_store.sv
module ctc_tag_store #(
  parameter int ENTRIES = 8,
  parameter int CTAG_W  = 6,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int WB     = ctc_pkg::TWORD_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [CTAG_W-1:0] rd_ctag,
  output logic [WB-1:0]     rd_word,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [CTAG_W-1:0] wr_ctag,
  input  logic [WB-1:0]     wr_word,
  input  logic              wr_dirty
);
  logic [WB-1:0]     data_mem [ENTRIES];
  logic [CTAG_W-1:0] ctag_mem [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] dirty_q;

  // Storage arrays carry no reset so they map onto distributed RAM.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      data_mem[wr_idx] <= wr_word;
      ctag_mem[wr_idx] <= wr_ctag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
      dirty_q[wr_idx] <= wr_dirty;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_ctag  = ctag_mem[rd_idx];
  assign rd_word  = data_mem[rd_idx];

  a_r9_store_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (valid_q == '0 && dirty_q == '0));

  a_r7_dirty_implies_valid: assert property (@(posedge clk) disable iff (rst)
    ((dirty_q & ~valid_q) == '0));
endmodule

// File: rtl/ctc_tag_cache.sv
module ctc_tag_cache
  import ctc_pkg::*;
#(
  parameter int LINE_AW = 16,
  parameter int ENTRIES = 8,
  parameter int MEM_AW  = 32,
  parameter logic [MEM_AW-1:0] TBL_BASE = 'h0010_0000,
  localparam int WORD_AW = LINE_AW - TBIT_W,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int CTAG_W  = WORD_AW - IDX_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [1:0]            req_op,
  input  logic [LINE_AW-1:0]    req_line,
  output logic                  rsp_valid,
  output logic                  rsp_tag,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic                  mem_req_we,
  output logic [MEM_AW-1:0]     mem_req_addr,
  output logic [TWORD_BITS-1:0] mem_req_wdata,
  input  logic                  mem_rsp_valid,
  input  logic [TWORD_BITS-1:0] mem_rsp_rdata
);
  localparam logic [MEM_AW-1:0] TBL_END =
    TBL_BASE + MEM_AW'((2 ** WORD_AW) * (TWORD_BITS / 8));

  ctc_state_e state_q, state_d;
  logic [LINE_AW-1:0] l_line;
  ctc_op_e            l_op;

  logic [LINE_AW-1:0] map_line;
  ctc_op_e            op_cur;
  logic [WORD_AW-1:0] m_word;
  logic [IDX_W-1:0]   m_idx;
  logic [CTAG_W-1:0]  m_ctag;
  logic [TBIT_W-1:0]  m_bit;

  logic                  rd_valid, rd_dirty, hit, pg_bit;
  logic [CTAG_W-1:0]     rd_ctag;
  logic [TWORD_BITS-1:0] rd_word, hit_word, fill_word;

  logic                  st_wr_en, st_wr_dirty;
  logic [TWORD_BITS-1:0] st_wr_word;
  logic                  sum_set, sum_clr;
  logic                  rsp_fire, rsp_val;
  logic                  latch, launch_wb, launch_rd;

  assign map_line = (state_q == ST_IDLE) ? req_line : l_line;
  assign op_cur   = (state_q == ST_IDLE) ? ctc_op_e'(req_op) : l_op;

  ctc_addr_map #(.LINE_AW(LINE_AW), .ENTRIES(ENTRIES)) u_map (
    .line(map_line), .word(m_word), .idx(m_idx), .ctag(m_ctag), .bit_idx(m_bit)
  );

  ctc_tag_store #(.ENTRIES(ENTRIES), .CTAG_W(CTAG_W)) u_store (
    .clk(clk), .rst(rst),
    .rd_idx(m_idx), .rd_valid(rd_valid), .rd_dirty(rd_dirty),
    .rd_ctag(rd_ctag), .rd_word(rd_word),
    .wr_en(st_wr_en), .wr_idx(m_idx), .wr_ctag(m_ctag),
    .wr_word(st_wr_word), .wr_dirty(st_wr_dirty)
  );

  // One summary bit per table word (a page of 128 lines).
  ctc_page_summary #(.PAGE_W(WORD_AW)) u_sum (
    .clk(clk), .rst(rst),
    .rd_page(m_word), .rd_bit(pg_bit),
    .set_en(sum_set), .set_page(m_word),
    .clr_en(sum_clr), .clr_page(m_word)
  );

  assign hit       = rd_valid && (rd_ctag == m_ctag);
  // An empty page means the word is all zero, whatever is cached or in memory.
  assign hit_word  = ctc_apply(pg_bit ? rd_word : '0, op_cur, m_bit);
  assign fill_word = ctc_apply(mem_rsp_rdata, op_cur, m_bit);

  always_comb begin
    state_d     = state_q;
    st_wr_en    = 1'b0;
    st_wr_dirty = 1'b0;
    st_wr_word  = hit_word;
    sum_set     = 1'b0;
    sum_clr     = 1'b0;
    rsp_fire    = 1'b0;
    rsp_val     = 1'b0;
    latch       = 1'b0;
    launch_wb   = 1'b0;
    launch_rd   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (op_cur == OP_PAGE_CLR) begin
            sum_clr  = 1'b1;
            rsp_fire = 1'b1;
          end else if (!pg_bit && op_cur != OP_SET) begin
            rsp_fire = 1'b1;
          end else if (hit) begin
            rsp_fire = 1'b1;
            rsp_val  = hit_word[m_bit];
            if (op_cur != OP_READ) begin
              st_wr_en    = 1'b1;
              st_wr_dirty = 1'b1;
            end
            sum_set = (op_cur == OP_SET);
          end else begin
            latch = 1'b1;
            if (rd_valid && rd_dirty) begin
              launch_wb = 1'b1;
              state_d   = ST_WB_REQ;
            end else begin
              state_d = ST_DECIDE;
            end
          end
        end
      end
      ST_WB_REQ: begin
        if (mem_req_valid && mem_req_ready) state_d = ST_WB_WAIT;
      end
      ST_WB_WAIT: begin
        if (mem_rsp_valid) state_d = ST_DECIDE;
      end
      ST_DECIDE: begin
        if (!pg_bit) begin
          st_wr_en    = 1'b1;
          st_wr_dirty = (op_cur != OP_READ);
          sum_set     = (op_cur == OP_SET);
          rsp_fire    = 1'b1;
          rsp_val     = hit_word[m_bit];
          state_d     = ST_IDLE;
        end else begin
          launch_rd = 1'b1;
          state_d   = ST_RD_REQ;
        end
      end
      ST_RD_REQ: begin
        if (mem_req_valid && mem_req_ready) state_d = ST_RD_WAIT;
      end
      ST_RD_WAIT: begin
        if (mem_rsp_valid) begin
          st_wr_en    = 1'b1;
          st_wr_word  = fill_word;
          st_wr_dirty = (op_cur != OP_READ);
          sum_set     = (op_cur == OP_SET);
          rsp_fire    = 1'b1;
          rsp_val     = fill_word[m_bit];
          state_d     = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      l_line        <= '0;
      l_op          <= OP_READ;
      rsp_valid     <= 1'b0;
      rsp_tag       <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_we    <= 1'b0;
      mem_req_addr  <= TBL_BASE;
      mem_req_wdata <= '0;
    end else begin
      state_q   <= state_d;
      rsp_valid <= rsp_fire;
      if (rsp_fire) rsp_tag <= rsp_val;
      if (latch) begin
        l_line <= req_line;
        l_op   <= op_cur;
      end
      if (launch_wb) begin
        mem_req_valid <= 1'b1;
        mem_req_we    <= 1'b1;
        mem_req_addr  <= TBL_BASE + (MEM_AW'({rd_ctag, m_idx}) << 4);
        mem_req_wdata <= rd_word;
      end else if (launch_rd) begin
        mem_req_valid <= 1'b1;
        mem_req_we    <= 1'b0;
        mem_req_addr  <= TBL_BASE + (MEM_AW'(m_word) << 4);
      end else if (mem_req_valid && mem_req_ready) begin
        mem_req_valid <= 1'b0;
      end
    end
  end

  assign req_ready = (state_q == ST_IDLE);

  a_r4_fetch_needs_summary: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_we) |-> pg_bit);

  a_r2_addr_in_table: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr >= TBL_BASE && mem_req_addr < TBL_END
                       && mem_req_addr[3:0] == 4'd0));

  a_r6_mem_req_held: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r6_rsp_when_ready: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_ready);

  a_r6_no_rsp_during_mem: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !rsp_valid);
endmodule

// File: tb/sim_ctc_tag_cache.sv
module sim_ctc_tag_cache;
  localparam logic [31:0] BASE = 32'h0010_0000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [1:0]   req_op = 2'd0;
  logic [15:0]  req_line = '0;
  logic         rsp_valid, rsp_tag;
  logic         mem_req_valid, mem_req_we;
  logic         mem_req_ready;
  logic [31:0]  mem_req_addr;
  logic [127:0] mem_req_wdata;
  logic         mem_rsp_valid = 1'b0;
  logic [127:0] mem_rsp_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  ctc_tag_cache u0 (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_line(req_line),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  // Table memory model: ready toggles, answers three cycles after acceptance.
  logic [127:0] tmem [0:511];
  logic         rdy_t = 1'b0;
  int           pend = 0;
  logic [127:0] pend_data = '0;
  int           n_rd = 0, n_wr = 0;
  logic [31:0]  last_ra = '0, last_wa = '0;
  logic [127:0] last_wd = '0;

  assign mem_req_ready = rdy_t;

  always @(posedge clk) begin
    rdy_t         <= rst ? 1'b0 : ~rdy_t;
    mem_rsp_valid <= 1'b0;
    if (rst) begin
      pend <= 0;
    end else if (pend != 0) begin
      pend <= pend - 1;
      if (pend == 1) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= pend_data;
      end
    end else if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        tmem[(mem_req_addr - BASE) >> 4] <= mem_req_wdata;
        n_wr    <= n_wr + 1;
        last_wa <= mem_req_addr;
        last_wd <= mem_req_wdata;
      end else begin
        pend_data <= tmem[(mem_req_addr - BASE) >> 4];
        n_rd      <= n_rd + 1;
        last_ra   <= mem_req_addr;
      end
      pend <= 3;
    end
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic [1:0] op, input logic [15:0] line,
                        output logic tag, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_line = line;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    tag = rsp_tag;
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    check(req_ready == 1'b1, "R9 ready after reset", req_ready, 1);
    check(rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R9 idle outputs",
          {rsp_valid, mem_req_valid}, 0);
  endtask

  task automatic t_cold_page;
    logic t; int lat; int r0, w0;
    r0 = n_rd; w0 = n_wr;
    do_req(2'd0, 16'h0105, t, lat);
    check(t == 1'b0, "R4 cold read tag", t, 0);
    check(lat == 1, "R6 cold read latency", lat, 1);
    do_req(2'd2, 16'h0105, t, lat);
    check(t == 1'b0 && lat == 1, "R4 cold clear", {t, 8'(lat)}, 1);
    check(n_rd == r0 && n_wr == w0, "R4 no traffic on empty page", n_rd + n_wr, r0 + w0);
  endtask

  task automatic t_set_empty_page;
    logic t; int lat; int r0;
    r0 = n_rd;
    do_req(2'd1, 16'h0105, t, lat);   // memory word 2 holds all ones
    check(t == 1'b1, "R3 set returns 1", t, 1);
    check(lat == 2, "R4 empty page set latency", lat, 2);
    check(n_rd == r0, "R4 no fetch for empty page set", n_rd, r0);
    do_req(2'd0, 16'h0106, t, lat);
    check(t == 1'b0 && lat == 1, "R4 zero word installed, hit", {t, 8'(lat)}, 1);
  endtask

  task automatic t_hits;
    logic t; int lat;
    do_req(2'd1, 16'h0107, t, lat);
    check(t == 1'b1 && lat == 1, "R6 set hit", {t, 8'(lat)}, 9'h101);
    do_req(2'd0, 16'h0107, t, lat);
    check(t == 1'b1, "R3 read after set", t, 1);
    do_req(2'd2, 16'h0107, t, lat);
    check(t == 1'b0 && lat == 1, "R3 clear hit", {t, 8'(lat)}, 1);
    do_req(2'd0, 16'h0107, t, lat);
    check(t == 1'b0, "R3 read after clear", t, 0);
  endtask

  task automatic t_evict_dirty;
    logic t; int lat; int r0, w0;
    r0 = n_rd; w0 = n_wr;
    do_req(2'd1, 16'h0503, t, lat);   // word 10, same index as word 2
    check(n_wr == w0 + 1, "R7 dirty victim written back", n_wr, w0 + 1);
    check(last_wa == BASE + 32'h20, "R2 write-back address", last_wa, BASE + 32'h20);
    check(last_wd == (128'h1 << 5), "R1 written word bit position", last_wd, 128'h1 << 5);
    check(n_rd == r0 && t == 1'b1, "R4 set on empty page, no fetch", n_rd, r0);
  endtask

  task automatic t_refetch;
    logic t; int lat; int r0, w0;
    r0 = n_rd; w0 = n_wr;
    do_req(2'd0, 16'h0105, t, lat);
    check(n_wr == w0 + 1 && last_wa == BASE + 32'hA0, "R7 second write-back",
          last_wa, BASE + 32'hA0);
    check(last_wd == (128'h1 << 3), "R1 word 10 bit 3", last_wd, 128'h1 << 3);
    check(n_rd == r0 + 1 && last_ra == BASE + 32'h20, "R2 fetch address", last_ra,
          BASE + 32'h20);
    check(t == 1'b1, "R3 tag survives eviction", t, 1);
    do_req(2'd0, 16'h0503, t, lat);
    check(n_wr == w0 + 1, "R7 clean victim not written", n_wr, w0 + 1);
    check(t == 1'b1 && last_ra == BASE + 32'hA0, "R2 refetch word 10", last_ra,
          BASE + 32'hA0);
  endtask

  task automatic t_index;
    logic t; int lat;
    do_req(2'd1, 16'h0185, t, lat);   // word 3, index 3
    do_req(2'd0, 16'h0503, t, lat);   // word 10 still resident at index 2
    check(t == 1'b1 && lat == 1, "R8 different index coexists", {t, 8'(lat)}, 9'h101);
  endtask

  task automatic t_page_clear;
    logic t; int lat; int r0;
    do_req(2'd3, 16'h0100, t, lat);
    check(t == 1'b0 && lat == 1, "R5 page clear response", {t, 8'(lat)}, 1);
    r0 = n_rd;
    do_req(2'd0, 16'h0105, t, lat);
    check(t == 1'b0 && lat == 1, "R5 cleared page reads 0", {t, 8'(lat)}, 1);
    do_req(2'd1, 16'h0110, t, lat);
    check(n_rd == r0 && t == 1'b1, "R5 set after page clear, no fetch", n_rd, r0);
    do_req(2'd0, 16'h0105, t, lat);
    check(t == 1'b0 && lat == 1, "R5 old tag stays cleared", {t, 8'(lat)}, 1);
  endtask

  task automatic t_reset_again;
    logic t; int lat; int r0, w0;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    r0 = n_rd; w0 = n_wr;
    do_req(2'd0, 16'h0503, t, lat);
    check(t == 1'b0 && lat == 1, "R9 tag reads 0 after reset", {t, 8'(lat)}, 1);
    do_req(2'd1, 16'h0503, t, lat);
    check(lat == 2 && n_rd == r0 && n_wr == w0, "R9 cache and summary empty",
          n_rd + n_wr, r0 + w0);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) tmem[i] = '0;
    tmem[2] = '1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_cold_page();
    t_set_empty_page();
    t_hits();
    t_evict_dirty();
    t_refetch();
    t_index();
    t_page_clear();
    t_reset_again();
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule